// File: doc/BRIEF.md
# DMA Channel Configuration Checker

This block is the per-channel setup store of a DMA controller. Software programs a mode word, the current and reload source addresses, the current and reload destination addresses, and the current and reload byte counts through a simple indexed write/read port. A control word carries the channel enable and a sticky configuration-error flag.

Each enable request is screened before the channel starts. The request can come from a control-word write or from the `start_req` pin. The screen checks the programmed transfer mode (cycle-stealing or pipelined) against the transfer condition (unit operand, sequential operand or non-stop) and the pairing of source and destination bus units. A prohibited setup leaves the channel off and sets the error flag. An accepted setup raises `chan_en` toward the transfer engine and freezes every setup register until the channel is switched off.

The engine reports each completed beat on `beat_done`. The block counts the current byte count down. When the count runs out, the block either stops the channel or, if reload is selected, copies the reload registers into the current ones and keeps running.

Top module: `dma_chan_cfg`

## Requirements
- R1: After reset every register reads zero, and `chan_en` and `cfg_err` are low.
- R2: While the channel is off, each setup register written at its index reads back the written value, truncated to its width. The indices are: 0 mode, 2 current source, 3 reload source, 4 current destination, 5 reload destination, 6 current count, 7 reload count. The mode word (UNIT_W=2) holds the condition in [1:0], the mode in [3:2], the source unit in [5:4], the destination unit in [7:6] and the reload select in [8].
- R3: The control word is at index 1, with enable at bit 0 and error at bit 1. Writing it with bit 0 set and a legal setup raises `chan_en` at the next clock edge, and control reads then return bit 0 = 1.
- R4: While the channel is on, writes to indices 0 and 2 to 7 are ignored.
- R5: Writing the control word with bit 0 clear always switches the channel off at the next edge. Setup writes in the following cycle take effect.
- R6: Cycle-stealing mode (code 00) is legal with conditions 00, 01 and 11, whether the source and destination units are the same or different.
- R7: Pipelined mode (code 01) with the source unit equal to the destination unit is refused: `chan_en` stays low and `cfg_err` sets.
- R8: Pipelined mode with non-stop condition (11) is refused when the destination unit equals EXT_UNIT. It is accepted when only the source unit is EXT_UNIT, and it is accepted with the unit-operand condition toward EXT_UNIT.
- R9: The reserved condition code 10 and the reserved mode codes 10 and 11 are always refused and set `cfg_err`.
- R10: `cfg_err` is sticky. A control write with bit 1 set clears it, and a control write with bit 1 clear leaves it set.
- R11: A one-cycle `start_req` pulse is screened exactly like an enable write: it enables a legal setup and flags an illegal one.
- R12: While the channel is on, each `beat_done` lowers the current count by BEAT_BYTES. The beat that takes the count to zero, with reload off, leaves the count at 0 and drops `chan_en`.
- R13: With reload selected, the beat that exhausts the count loads the current source, destination and count from their reload registers, and `chan_en` stays high.
- R14: `beat_done` while the channel is off leaves the current count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_ix | input | 3 | Register index for writes |
| wr_data | input | DATA_W | Write data |
| rd_ix | input | 3 | Register index for reads |
| rd_data | output | DATA_W | Read data (combinational) |
| start_req | input | 1 | Hardware start request, screened like an enable write |
| beat_done | input | 1 | One beat of BEAT_BYTES completed by the engine |
| chan_en | output | 1 | Channel enable toward the transfer engine |
| cfg_err | output | 1 | Sticky illegal-setup flag |

## Verification
The bench builds the block with ADDR_W=16, CNT_W=8, BEAT_BYTES=4 and EXT_UNIT=2 instead of the defaults. The narrow count lets a run-down to zero and a reload happen within a few beats. Moving the external unit off its default code shows that the non-stop prohibition follows the parameter and not a fixed value. The narrow address and count widths also check the truncation and zero-extension on readback.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;

   localparam int IX_W = 3;

   typedef enum logic [IX_W-1:0] {
      IX_MODE = 3'd0,
      IX_CTRL = 3'd1,
      IX_CSRC = 3'd2,
      IX_RSRC = 3'd3,
      IX_CDST = 3'd4,
      IX_RDST = 3'd5,
      IX_CCNT = 3'd6,
      IX_RCNT = 3'd7
   } reg_ix_e;

   typedef enum logic [1:0] {
      XC_UNIT    = 2'b00,
      XC_SEQ     = 2'b01,
      XC_RSV     = 2'b10,
      XC_NONSTOP = 2'b11
   } xcond_e;

   typedef enum logic [1:0] {
      XM_CSTEAL = 2'b00,
      XM_PIPE   = 2'b01,
      XM_RSV2   = 2'b10,
      XM_RSV3   = 2'b11
   } xmode_e;

   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_ERR_BIT = 1;
   localparam int COND_LSB     = 0;
   localparam int XMODE_LSB    = 2;
   localparam int UNIT_LSB     = 4;

endpackage

// File: rtl/dma_cfg_legal.sv
module dma_cfg_legal
   import dma_cfg_pkg::*;
#(
   parameter int UNIT_W   = 2,
   parameter int EXT_UNIT = 3
)(
   input  logic [1:0]        xcond_i,
   input  logic [1:0]        xmode_i,
   input  logic [UNIT_W-1:0] src_unit_i,
   input  logic [UNIT_W-1:0] dst_unit_i,
   output logic              legal_o
);

   localparam logic [UNIT_W-1:0] EXT_C = UNIT_W'(EXT_UNIT);

   xcond_e cond;
   xmode_e mode;
   logic   same_unit;
   logic   to_ext;

   assign cond      = xcond_e'(xcond_i);
   assign mode      = xmode_e'(xmode_i);
   assign same_unit = (src_unit_i == dst_unit_i);
   assign to_ext    = (dst_unit_i == EXT_C);

   always_comb begin
      legal_o = 1'b1;
      if (cond == XC_RSV) legal_o = 1'b0;
      case (mode)
         XM_CSTEAL: ;
         XM_PIPE: begin
            if (same_unit) legal_o = 1'b0;
            if ((cond == XC_NONSTOP) && to_ext) legal_o = 1'b0;
         end
         default: legal_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
   import dma_cfg_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 24,
   parameter int UNIT_W     = 2,
   parameter int BEAT_BYTES = 4,
   parameter bit RELOAD_EN  = 1'b1,
   parameter int MODE_W     = 5 + 2*UNIT_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [IX_W-1:0]   wr_ix_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [IX_W-1:0]   rd_ix_i,
   input  logic              lock_i,
   input  logic              beat_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [MODE_W-1:0] mode_o,
   output logic [1:0]        xcond_o,
   output logic [1:0]        xmode_o,
   output logic [UNIT_W-1:0] src_unit_o,
   output logic [UNIT_W-1:0] dst_unit_o,
   output logic              reload_sel_o,
   output logic              cnt_last_o
);

   localparam int DST_LSB = UNIT_LSB + UNIT_W;
   localparam int RLD_BIT = UNIT_LSB + 2*UNIT_W;
   localparam logic [CNT_W-1:0] BEAT_C = CNT_W'(BEAT_BYTES);

   logic [MODE_W-1:0] mode_q;
   logic [ADDR_W-1:0] cur_src_q, cur_dst_q;
   logic [CNT_W-1:0]  cur_cnt_q;
   logic [ADDR_W-1:0] rld_src, rld_dst;
   logic [CNT_W-1:0]  rld_cnt;
   logic              cfg_wr;
   reg_ix_e           wix, rix;

   assign wix    = reg_ix_e'(wr_ix_i);
   assign rix    = reg_ix_e'(rd_ix_i);
   assign cfg_wr = wr_en_i && !lock_i;

   assign mode_o     = mode_q;
   assign xcond_o    = mode_q[COND_LSB +: 2];
   assign xmode_o    = mode_q[XMODE_LSB +: 2];
   assign src_unit_o = mode_q[UNIT_LSB +: UNIT_W];
   assign dst_unit_o = mode_q[DST_LSB +: UNIT_W];
   assign cnt_last_o = (cur_cnt_q <= BEAT_C);

   // Mode word and current registers: software writes while unlocked,
   // countdown and reload while the channel runs.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= '0;
         cur_src_q <= '0;
         cur_dst_q <= '0;
         cur_cnt_q <= '0;
      end else if (cfg_wr) begin
         case (wix)
            IX_MODE: mode_q    <= wr_data_i[MODE_W-1:0];
            IX_CSRC: cur_src_q <= wr_data_i[ADDR_W-1:0];
            IX_CDST: cur_dst_q <= wr_data_i[ADDR_W-1:0];
            IX_CCNT: cur_cnt_q <= wr_data_i[CNT_W-1:0];
            default: ;
         endcase
      end else if (beat_i) begin
         if (!cnt_last_o) begin
            cur_cnt_q <= cur_cnt_q - BEAT_C;
         end else if (reload_sel_o) begin
            cur_src_q <= rld_src;
            cur_dst_q <= rld_dst;
            cur_cnt_q <= rld_cnt;
         end else begin
            cur_cnt_q <= '0;
         end
      end
   end

   generate
      if (RELOAD_EN) begin : g_reload
         logic [ADDR_W-1:0] rsrc_q, rdst_q;
         logic [CNT_W-1:0]  rcnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rsrc_q <= '0;
               rdst_q <= '0;
               rcnt_q <= '0;
            end else if (cfg_wr) begin
               case (wix)
                  IX_RSRC: rsrc_q <= wr_data_i[ADDR_W-1:0];
                  IX_RDST: rdst_q <= wr_data_i[ADDR_W-1:0];
                  IX_RCNT: rcnt_q <= wr_data_i[CNT_W-1:0];
                  default: ;
               endcase
            end
         end
         assign rld_src      = rsrc_q;
         assign rld_dst      = rdst_q;
         assign rld_cnt      = rcnt_q;
         assign reload_sel_o = mode_q[RLD_BIT];
      end else begin : g_noreload
         assign rld_src      = '0;
         assign rld_dst      = '0;
         assign rld_cnt      = '0;
         assign reload_sel_o = 1'b0;
      end
   endgenerate

   always_comb begin
      rd_data_o = '0;
      case (rix)
         IX_MODE: rd_data_o = DATA_W'(mode_q);
         IX_CSRC: rd_data_o = DATA_W'(cur_src_q);
         IX_RSRC: rd_data_o = DATA_W'(rld_src);
         IX_CDST: rd_data_o = DATA_W'(cur_dst_q);
         IX_RDST: rd_data_o = DATA_W'(rld_dst);
         IX_CCNT: rd_data_o = DATA_W'(cur_cnt_q);
         IX_RCNT: rd_data_o = DATA_W'(rld_cnt);
         default: rd_data_o = '0;
      endcase
   end

endmodule

// File: rtl/dma_cfg_enctl.sv
module dma_cfg_enctl (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req_i,
   input  logic off_req_i,
   input  logic err_clr_i,
   input  logic legal_i,
   input  logic done_stop_i,
   output logic en_o,
   output logic err_o
);

   logic en_q, err_q;
   logic try_start;

   assign try_start = set_req_i && !off_req_i && !en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         err_q <= 1'b0;
      end else begin
         if (off_req_i || done_stop_i)  en_q <= 1'b0;
         else if (try_start && legal_i) en_q <= 1'b1;

         if (try_start && !legal_i) err_q <= 1'b1;
         else if (err_clr_i)        err_q <= 1'b0;
      end
   end

   assign en_o  = en_q;
   assign err_o = err_q;

endmodule

// File: rtl/dma_chan_cfg.sv
module dma_chan_cfg
   import dma_cfg_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 24,
   parameter int UNIT_W     = 2,
   parameter int EXT_UNIT   = 3,
   parameter int BEAT_BYTES = 4,
   parameter bit RELOAD_EN  = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_ix,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        rd_ix,
   output logic [DATA_W-1:0] rd_data,
   input  logic              start_req,
   input  logic              beat_done,
   output logic              chan_en,
   output logic              cfg_err
);

   localparam int MODE_W = 5 + 2*UNIT_W;

   generate
      if (DATA_W < ADDR_W || DATA_W < CNT_W || DATA_W < MODE_W) begin : g_bad_data_w
         $error("DATA_W too narrow for the setup registers");
      end
      if (EXT_UNIT < 0 || EXT_UNIT >= (1 << UNIT_W)) begin : g_bad_ext
         $error("EXT_UNIT outside the bus-unit code range");
      end
      if (BEAT_BYTES < 1 || BEAT_BYTES >= (1 << CNT_W)) begin : g_bad_beat
         $error("BEAT_BYTES must fit the byte counter");
      end
   endgenerate

   logic [DATA_W-1:0] cfg_rd;
   logic [MODE_W-1:0] mode_raw;
   logic [1:0]        xcond, xmode;
   logic [UNIT_W-1:0] src_unit, dst_unit;
   logic              reload_sel, cnt_last, legal;
   logic              ctrl_wr, set_req, off_req, err_clr, beat, done_stop;

   assign ctrl_wr   = wr_en && (wr_ix == IX_CTRL);
   assign set_req   = start_req || (ctrl_wr && wr_data[CTRL_EN_BIT]);
   assign off_req   = ctrl_wr && !wr_data[CTRL_EN_BIT];
   assign err_clr   = ctrl_wr && wr_data[CTRL_ERR_BIT];
   assign beat      = beat_done && chan_en;
   assign done_stop = beat && cnt_last && !reload_sel;

   dma_cfg_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .UNIT_W(UNIT_W),
      .BEAT_BYTES(BEAT_BYTES), .RELOAD_EN(RELOAD_EN), .MODE_W(MODE_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en), .wr_ix_i(wr_ix), .wr_data_i(wr_data),
      .rd_ix_i(rd_ix), .lock_i(chan_en), .beat_i(beat),
      .rd_data_o(cfg_rd), .mode_o(mode_raw),
      .xcond_o(xcond), .xmode_o(xmode),
      .src_unit_o(src_unit), .dst_unit_o(dst_unit),
      .reload_sel_o(reload_sel), .cnt_last_o(cnt_last)
   );

   dma_cfg_legal #(.UNIT_W(UNIT_W), .EXT_UNIT(EXT_UNIT)) u_legal (
      .xcond_i(xcond), .xmode_i(xmode),
      .src_unit_i(src_unit), .dst_unit_i(dst_unit),
      .legal_o(legal)
   );

   dma_cfg_enctl u_enctl (
      .clk(clk), .rst_n(rst_n),
      .set_req_i(set_req), .off_req_i(off_req), .err_clr_i(err_clr),
      .legal_i(legal), .done_stop_i(done_stop),
      .en_o(chan_en), .err_o(cfg_err)
   );

   always_comb begin
      if (rd_ix == IX_CTRL) begin
         rd_data = '0;
         rd_data[CTRL_EN_BIT]  = chan_en;
         rd_data[CTRL_ERR_BIT] = cfg_err;
      end else begin
         rd_data = cfg_rd;
      end
   end

endmodule

// File: rtl/dma_chan_cfg_chk.sv
module dma_chan_cfg_chk #(
   parameter int MODE_W = 9
)(
   input logic              clk,
   input logic              rst_n,
   input logic              chan_en,
   input logic              cfg_err,
   input logic              legal,
   input logic [MODE_W-1:0] mode_raw,
   input logic [1:0]        xcond,
   input logic              off_req,
   input logic              done_stop,
   input logic              err_clr
);

   // R3
   en_rise_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_en) |-> $past(legal));

   // R4
   cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en |=> $stable(mode_raw));

   // R7
   err_rise_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_err) |-> $past(!legal));

   // R9
   rsv_cond_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xcond == 2'b10) |-> !legal);

   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && !err_clr) |=> cfg_err);

   // R12
   en_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chan_en) |-> $past(off_req || done_stop));

endmodule

bind dma_chan_cfg dma_chan_cfg_chk #(.MODE_W(MODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cfg_err(cfg_err),
   .legal(legal), .mode_raw(mode_raw), .xcond(xcond),
   .off_req(off_req), .done_stop(done_stop), .err_clr(err_clr)
);

// File: tb/sim_dma_chan_cfg.sv
module sim_dma_chan_cfg;

   localparam int DW = 32;
   localparam int EXT = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_ix = '0;
   logic [DW-1:0] wr_data = '0;
   logic [2:0]    rd_ix = '0;
   logic [DW-1:0] rd_data;
   logic          start_req = 1'b0;
   logic          beat_done = 1'b0;
   logic          chan_en, cfg_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dma_chan_cfg #(
      .DATA_W(DW), .ADDR_W(16), .CNT_W(8), .UNIT_W(2),
      .EXT_UNIT(EXT), .BEAT_BYTES(4), .RELOAD_EN(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ix(wr_ix),
      .wr_data(wr_data), .rd_ix(rd_ix), .rd_data(rd_data),
      .start_req(start_req), .beat_done(beat_done),
      .chan_en(chan_en), .cfg_err(cfg_err)
   );

   function automatic logic [31:0] mk(input logic [1:0] c, input logic [1:0] m,
                                      input logic [1:0] s, input logic [1:0] d,
                                      input logic r);
      return {23'd0, r, d, s, m, c};
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] ix, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_ix = ix; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] ix, output logic [31:0] d);
      rd_ix = ix;
      #1;
      d = rd_data;
   endtask

   task automatic pulse_beat();
      @(negedge clk); beat_done = 1'b1;
      @(negedge clk); beat_done = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk); start_req = 1'b1;
      @(negedge clk); start_req = 1'b0;
   endtask

   task automatic off_and_clear();
      wr(3'd1, 32'h2);
   endtask

   // Program a mode, request enable by write, expect accept or refuse.
   task automatic try_mode(input string req, input logic [31:0] m, input bit ok);
      wr(3'd0, m);
      wr(3'd1, 32'h1);
      chk({req, " chan_en"}, {31'd0, chan_en}, {31'd0, ok});
      chk({req, " cfg_err"}, {31'd0, cfg_err}, {31'd0, !ok});
      off_and_clear();
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int i = 0; i < 8; i++) begin
         rd(3'(i), v);
         chk("R1 reg zero", v, 32'd0);
      end
      chk("R1 chan_en", {31'd0, chan_en}, 32'd0);
      chk("R1 cfg_err", {31'd0, cfg_err}, 32'd0);
   endtask

   task automatic t_rw();
      logic [31:0] v;
      wr(3'd0, 32'hFFFF_F1A5); rd(3'd0, v); chk("R2 mode", v, 32'h1A5);
      wr(3'd2, 32'hABCD_1234); rd(3'd2, v); chk("R2 cur src", v, 32'h1234);
      wr(3'd3, 32'h0000_5678); rd(3'd3, v); chk("R2 rld src", v, 32'h5678);
      wr(3'd4, 32'h0000_9ABC); rd(3'd4, v); chk("R2 cur dst", v, 32'h9ABC);
      wr(3'd5, 32'h0000_DEF0); rd(3'd5, v); chk("R2 rld dst", v, 32'hDEF0);
      wr(3'd6, 32'h0000_0177); rd(3'd6, v); chk("R2 cur cnt", v, 32'h77);
      wr(3'd7, 32'h0000_0033); rd(3'd7, v); chk("R2 rld cnt", v, 32'h33);
   endtask

   task automatic t_lock();
      logic [31:0] v;
      wr(3'd0, mk(2'b00, 2'b00, 2'd0, 2'd1, 1'b0));
      wr(3'd2, 32'h1111);
      wr(3'd1, 32'h1);
      chk("R3 en after write", {31'd0, chan_en}, 32'd1);
      rd(3'd1, v); chk("R3 ctrl read", v, 32'h1);
      wr(3'd0, mk(2'b01, 2'b01, 2'd2, 2'd3, 1'b1));
      wr(3'd2, 32'h2222);
      wr(3'd6, 32'h55);
      rd(3'd0, v); chk("R4 mode locked", v, mk(2'b00, 2'b00, 2'd0, 2'd1, 1'b0));
      rd(3'd2, v); chk("R4 src locked", v, 32'h1111);
      rd(3'd6, v); chk("R4 cnt locked", v, 32'h77);
      wr(3'd1, 32'h0);
      chk("R5 disable", {31'd0, chan_en}, 32'd0);
      wr(3'd2, 32'h3333);
      rd(3'd2, v); chk("R5 unlocked", v, 32'h3333);
   endtask

   task automatic t_csteal();
      logic [1:0] conds [3] = '{2'b00, 2'b01, 2'b11};
      foreach (conds[k]) begin
         try_mode("R6 cs diff", mk(conds[k], 2'b00, 2'd0, 2'd3, 1'b0), 1'b1);
         try_mode("R6 cs same", mk(conds[k], 2'b00, 2'd2, 2'd2, 1'b0), 1'b1);
      end
   endtask

   task automatic t_pipe_same();
      wr(3'd0, mk(2'b01, 2'b01, 2'd1, 2'd1, 1'b0));
      wr(3'd1, 32'h1);
      chk("R7 refused", {31'd0, chan_en}, 32'd0);
      chk("R7 err set", {31'd0, cfg_err}, 32'd1);
      wr(3'd1, 32'h0);
      chk("R10 err sticky", {31'd0, cfg_err}, 32'd1);
      wr(3'd1, 32'h2);
      chk("R10 err cleared", {31'd0, cfg_err}, 32'd0);
      try_mode("R7 pipe diff ok", mk(2'b01, 2'b01, 2'd0, 2'd1, 1'b0), 1'b1);
   endtask

   task automatic t_ext();
      try_mode("R8 nonstop to ext", mk(2'b11, 2'b01, 2'd0, 2'(EXT), 1'b0), 1'b0);
      try_mode("R8 nonstop from ext", mk(2'b11, 2'b01, 2'(EXT), 2'd0, 1'b0), 1'b1);
      try_mode("R8 unit op to ext", mk(2'b00, 2'b01, 2'd0, 2'(EXT), 1'b0), 1'b1);
      try_mode("R8 nonstop to non-ext", mk(2'b11, 2'b01, 2'd0, 2'd3, 1'b0), 1'b1);
   endtask

   task automatic t_reserved();
      try_mode("R9 cond 10 cs", mk(2'b10, 2'b00, 2'd0, 2'd1, 1'b0), 1'b0);
      try_mode("R9 mode 10", mk(2'b00, 2'b10, 2'd0, 2'd1, 1'b0), 1'b0);
      try_mode("R9 mode 11", mk(2'b01, 2'b11, 2'd0, 2'd1, 1'b0), 1'b0);
   endtask

   task automatic t_start();
      wr(3'd0, mk(2'b01, 2'b00, 2'd0, 2'd1, 1'b0));
      pulse_start();
      chk("R11 start legal", {31'd0, chan_en}, 32'd1);
      off_and_clear();
      wr(3'd0, mk(2'b00, 2'b01, 2'd3, 2'd3, 1'b0));
      pulse_start();
      chk("R11 start illegal en", {31'd0, chan_en}, 32'd0);
      chk("R11 start illegal err", {31'd0, cfg_err}, 32'd1);
      off_and_clear();
   endtask

   task automatic t_count();
      logic [31:0] v;
      wr(3'd0, mk(2'b00, 2'b00, 2'd0, 2'd1, 1'b0));
      wr(3'd6, 32'd12);
      pulse_beat();
      rd(3'd6, v); chk("R14 beat while off", v, 32'd12);
      wr(3'd1, 32'h1);
      pulse_beat();
      rd(3'd6, v); chk("R12 count 8", v, 32'd8);
      chk("R12 still on", {31'd0, chan_en}, 32'd1);
      pulse_beat();
      pulse_beat();
      rd(3'd6, v); chk("R12 count 0", v, 32'd0);
      chk("R12 stopped", {31'd0, chan_en}, 32'd0);
   endtask

   task automatic t_reload();
      logic [31:0] v;
      wr(3'd0, mk(2'b11, 2'b00, 2'd0, 2'd1, 1'b1));
      wr(3'd2, 32'h0100); wr(3'd3, 32'h0A00);
      wr(3'd4, 32'h0200); wr(3'd5, 32'h0B00);
      wr(3'd6, 32'd8);    wr(3'd7, 32'd20);
      wr(3'd1, 32'h1);
      pulse_beat();
      pulse_beat();
      rd(3'd6, v); chk("R13 cnt reloaded", v, 32'd20);
      rd(3'd2, v); chk("R13 src reloaded", v, 32'h0A00);
      rd(3'd4, v); chk("R13 dst reloaded", v, 32'h0B00);
      chk("R13 stays on", {31'd0, chan_en}, 32'd1);
      off_and_clear();
   endtask

   initial begin
      #400000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rw();
      t_lock();
      t_csteal();
      t_pipe_same();
      t_ext();
      t_reserved();
      t_start();
      t_count();
      t_reload();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule